// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit execution stage of a small accumulator-style processor. It holds the working register W and pairs it with a second operand. That operand comes either from the data-store read port or from an 8-bit constant carried in the instruction. Every cycle with the clock enable high, it runs one operation: add, subtract, a bitwise function, move, complement, clear, increment, decrement, a rotate through carry, or a direct load of the flags. It then sends the result to one of two places.

A one-bit destination selects where the result goes. With the bit low, the result is written into W at the clock edge. With the bit high, the result appears combinationally on the file write port with a write strobe, and the data store captures it on the same edge. The three flags (carry, digit carry, zero) sit in a small status register. The carry flag is never cleared by reset. After a subtraction it holds the inverse of the borrow, and it also serves as the ninth bit of both rotates.

Top module: `acc_alu`

## Requirements
- R1: With `use_lit` at 1 the second operand B is `lit`; with `use_lit` at 0 it is `file_rdata`. The input that is not selected has no effect.
- R2: For any result-producing opcode, with `dest` at 0 the result is loaded into W and `file_we` stays 0. With `dest` at 1, `file_we` is 1 and `file_wdata` carries the result in that same cycle, and W keeps its value.
- R3: ADD (op 4'h1) gives W+B modulo 256. C becomes the carry out of bit 7 and DC the carry out of bit 3.
- R4: SUB (op 4'h2) gives B−W modulo 256. C is 1 exactly when B ≥ W (no borrow), and DC is 1 exactly when B[3:0] ≥ W[3:0].
- R5: Z (status bit 2) becomes 1 when the 8-bit result is 00h and 0 otherwise. This applies to MOV (4'h0), ADD, SUB, AND (4'h3), IOR (4'h4), XOR (4'h5), INC (4'h6, B+1), DEC (4'h7, B−1), COM (4'h8, ~B) and CLR (4'h9, result 00h).
- R6: MOV, AND, IOR, XOR, INC, DEC, COM and CLR leave C (status bit 0) and DC (status bit 1) unchanged.
- R7: RLC (op 4'hA) gives {B[6:0], C} and loads C from B[7]. RRC (op 4'hB) gives {C, B[7:1]} and loads C from B[0]. Both rotates leave Z and DC unchanged.
- R8: LDST (op 4'hC) loads C, DC and Z from B[0], B[1] and B[2], writes neither W nor the file, and keeps `file_we` at 0.
- R9: With `ce` at 0, `file_we` is 0 and neither W nor any flag changes. Opcodes 4'hD, 4'hE and 4'hF behave the same way even with `ce` at 1.
- R10: A clock edge with `rst_n` at 0 clears W, DC and Z. It leaves C at its previous value, even if an update is requested in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; executes the presented operation |
| op | input | 4 | Operation code |
| use_lit | input | 1 | 1 selects the literal as operand B, 0 selects the file read data |
| lit | input | 8 | Literal operand from the instruction |
| file_rdata | input | 8 | Data-store read value |
| dest | input | 1 | Result target: 0 to W, 1 to the file |
| file_wdata | output | 8 | Result offered to the data store |
| file_we | output | 1 | Data-store write strobe |
| w_q | output | 8 | Current working register value |
| stat_c | output | 1 | Carry flag (status bit 0) |
| stat_dc | output | 1 | Digit carry flag (status bit 1) |
| stat_z | output | 1 | Zero flag (status bit 2) |

## Verification
A corrupted W shows up directly on `w_q` after the edge. It also shows up one cycle later on `file_wdata` for any ADD or SUB, because W feeds every arithmetic result. A wrong carry flag is visible on `stat_c` right away and spreads into the next rotate result, so the bench follows each rotate with a check of both the result bits and the flag. Flag retention is easy to get wrong, so each case starts from preloaded flag values that the operation under test must leave alone. Those values then have to read back unchanged one cycle after the edge.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths and operation codes for the accumulator ALU.
// Assumes an 8-bit datapath split into two 4-bit halves for digit carry.
package acc_alu_pkg;

    localparam int ALU_DW  = 8;
    localparam int ALU_LOW = 4;
    localparam int ALU_OPW = 4;

    typedef enum logic [ALU_OPW-1:0] {
        OP_MOV  = 4'h0,
        OP_ADD  = 4'h1,
        OP_SUB  = 4'h2,
        OP_AND  = 4'h3,
        OP_IOR  = 4'h4,
        OP_XOR  = 4'h5,
        OP_INC  = 4'h6,
        OP_DEC  = 4'h7,
        OP_COM  = 4'h8,
        OP_CLR  = 4'h9,
        OP_RLC  = 4'hA,
        OP_RRC  = 4'hB,
        OP_LDST = 4'hC
    } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: split adder/subtractor. Computes a+b or a-b (as a + ~b + 1),
// with the carry out of the low part and of the full word.
// Assumes 0 < LOW < DW. In subtract mode a carry out means no borrow.
module acc_alu_addsub #(
    parameter int DW  = 8,
    parameter int LOW = 4
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hcout_o
);
    localparam int HIW = DW - LOW;

    logic [DW-1:0] b_eff;
    logic [LOW:0]  lo_sum;
    logic [HIW:0]  hi_sum;

    // Invert the right operand for subtraction.
    always_comb b_eff = sub_i ? ~b_i : b_i;

    // Low part, seeded with the subtract carry-in.
    always_comb lo_sum = {1'b0, a_i[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                       + {{LOW{1'b0}}, sub_i};

    // High part, chained from the low part's carry.
    always_comb hi_sum = {1'b0, a_i[DW-1:LOW]} + {1'b0, b_eff[DW-1:LOW]}
                       + {{HIW{1'b0}}, lo_sum[LOW]};

    // Assemble result and carries.
    always_comb begin
        sum_o   = {hi_sum[HIW-1:0], lo_sum[LOW-1:0]};
        cout_o  = hi_sum[HIW];
        hcout_o = lo_sum[LOW];
    end
endmodule

// File: rtl/acc_alu_logic.sv
// Module: non-arithmetic results: move, bitwise functions, complement,
// clear and the two rotates through carry.
// Assumes the caller ignores cout_o for anything but a rotate.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [ALU_OPW-1:0] op_i,
    input  logic [DW-1:0]      w_i,
    input  logic [DW-1:0]      b_i,
    input  logic               cin_i,
    output logic [DW-1:0]      res_o,
    output logic               cout_o
);
    // Pick the result and shifted-out bit for the requested operation.
    always_comb begin
        res_o  = b_i;
        cout_o = cin_i;
        case (op_i)
            OP_AND: res_o = w_i & b_i;
            OP_IOR: res_o = w_i | b_i;
            OP_XOR: res_o = w_i ^ b_i;
            OP_COM: res_o = ~b_i;
            OP_CLR: res_o = '0;
            OP_RLC: begin
                res_o  = {b_i[DW-2:0], cin_i};
                cout_o = b_i[DW-1];
            end
            OP_RRC: begin
                res_o  = {cin_i, b_i[DW-1:1]};
                cout_o = b_i[0];
            end
            default: res_o = b_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_flags.sv
// Module: status register holding carry, digit carry and zero.
// Assumes a synchronous active-low reset that clears DC and Z only. C has
// no reset value and holds through reset.
module acc_alu_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_i,
    input  logic       ld_all_i,
    input  logic [2:0] ld_val_i,
    input  logic       upd_c_i,
    input  logic       c_i,
    input  logic       upd_dc_i,
    input  logic       dc_i,
    input  logic       upd_z_i,
    input  logic       z_i,
    output logic       c_q,
    output logic       dc_q,
    output logic       z_q
);
    // Carry: updated only outside reset, never initialised.
    always_ff @(posedge clk) begin
        if (rst_n && ce_i) begin
            if (ld_all_i)     c_q <= ld_val_i[0];
            else if (upd_c_i) c_q <= c_i;
        end
    end

    // Digit carry: cleared by reset, otherwise loaded on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        dc_q <= 1'b0;
        else if (ce_i) begin
            if (ld_all_i)      dc_q <= ld_val_i[1];
            else if (upd_dc_i) dc_q <= dc_i;
        end
    end

    // Zero: cleared by reset, otherwise loaded on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        z_q <= 1'b0;
        else if (ce_i) begin
            if (ld_all_i)     z_q <= ld_val_i[2];
            else if (upd_z_i) z_q <= z_i;
        end
    end

    // R9: a disabled cycle freezes all flags.
    a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> ($stable(dc_q) && $stable(z_q) && $stable(c_q)));

    // R8: a status load lands all three bits.
    a_r8_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && ld_all_i) |=> ({z_q, dc_q, c_q} == $past(ld_val_i)));
endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Selects operand B, decodes the opcode, runs
// the shared adder or the logic unit, steers the result to W or the file
// port, and updates the status flags.
// Assumes file_wdata/file_we are captured by the data store on the same
// clock edge; the write port is combinational from the inputs and W.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW  = ALU_DW,
    parameter int LOW = ALU_LOW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic [ALU_OPW-1:0] op,
    input  logic               use_lit,
    input  logic [DW-1:0]      lit,
    input  logic [DW-1:0]      file_rdata,
    input  logic               dest,
    output logic [DW-1:0]      file_wdata,
    output logic               file_we,
    output logic [DW-1:0]      w_q,
    output logic               stat_c,
    output logic               stat_dc,
    output logic               stat_z
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] opnd;
    logic [DW-1:0] add_b, add_res, log_res, result;
    logic          add_cout, add_hcout, log_cout;
    logic          use_add, do_sub, use_one, wr_res;
    logic          upd_c, upd_dc, upd_z, ld_stat;

    // Operand B from the literal or the data store.
    always_comb opnd = use_lit ? lit : file_rdata;

    // Opcode decode into datapath and flag controls.
    always_comb begin
        use_add = 1'b0;
        do_sub  = 1'b0;
        use_one = 1'b0;
        wr_res  = 1'b1;
        upd_c   = 1'b0;
        upd_dc  = 1'b0;
        upd_z   = 1'b0;
        ld_stat = 1'b0;
        case (op)
            OP_ADD: begin use_add = 1'b1; upd_c = 1'b1; upd_dc = 1'b1; upd_z = 1'b1; end
            OP_SUB: begin use_add = 1'b1; do_sub = 1'b1; upd_c = 1'b1; upd_dc = 1'b1; upd_z = 1'b1; end
            OP_INC: begin use_add = 1'b1; use_one = 1'b1; upd_z = 1'b1; end
            OP_DEC: begin use_add = 1'b1; use_one = 1'b1; do_sub = 1'b1; upd_z = 1'b1; end
            OP_MOV, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_CLR: upd_z = 1'b1;
            OP_RLC, OP_RRC: upd_c = 1'b1;
            OP_LDST: begin wr_res = 1'b0; ld_stat = 1'b1; end
            default: wr_res = 1'b0;
        endcase
    end

    // Right adder input: W, or one for increment/decrement.
    always_comb add_b = use_one ? ONE : w_q;

    acc_alu_addsub #(.DW(DW), .LOW(LOW)) u_addsub (
        .a_i     (opnd),
        .b_i     (add_b),
        .sub_i   (do_sub),
        .sum_o   (add_res),
        .cout_o  (add_cout),
        .hcout_o (add_hcout)
    );

    acc_alu_logic #(.DW(DW)) u_logic (
        .op_i   (op),
        .w_i    (w_q),
        .b_i    (opnd),
        .cin_i  (stat_c),
        .res_o  (log_res),
        .cout_o (log_cout)
    );

    // Final result select.
    always_comb result = use_add ? add_res : log_res;

    // File write port driven in the execute cycle.
    always_comb begin
        file_wdata = result;
        file_we    = ce && wr_res && dest;
    end

    // Working register: cleared by reset, loaded when dest selects W.
    always_ff @(posedge clk) begin
        if (!rst_n)                  w_q <= '0;
        else if (ce && wr_res && !dest) w_q <= result;
    end

    acc_alu_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (ce),
        .ld_all_i (ld_stat),
        .ld_val_i (opnd[2:0]),
        .upd_c_i  (upd_c),
        .c_i      (use_add ? add_cout : log_cout),
        .upd_dc_i (upd_dc),
        .dc_i     (add_hcout),
        .upd_z_i  (upd_z),
        .z_i      (result == '0),
        .c_q      (stat_c),
        .dc_q     (stat_dc),
        .z_q      (stat_z)
    );

    // R2: a file write leaves W alone.
    a_r2_file_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
        file_we |=> $stable(w_q));

    // R3: addition into W is modulo 2^DW.
    a_r3_add_into_w: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && op == OP_ADD && !dest) |=> (w_q == DW'($past(w_q) + $past(opnd))));

    // R4: subtract carry is the inverse of borrow.
    a_r4_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && op == OP_SUB) |=> (stat_c == ($past(opnd) >= $past(w_q))));

    // R5: a bitwise result in W agrees with the zero flag.
    a_r5_zero_matches_w: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && op == OP_AND && !dest) |=> (stat_z == (w_q == '0)));

    // R6: non-arithmetic operations keep C and DC.
    a_r6_keep_carries: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (op inside {OP_MOV, OP_AND, OP_IOR, OP_XOR, OP_INC, OP_DEC, OP_COM, OP_CLR}))
        |=> ($stable(stat_c) && $stable(stat_dc)));

    // R7: left rotate shifts the top bit into carry.
    a_r7_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && op == OP_RLC) |=> (stat_c == $past(opnd[DW-1])));

    // R8: status load writes neither W nor file.
    a_r8_ldst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && op == OP_LDST) |=> $stable(w_q));

    // R9: no strobe without enable.
    a_r9_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> !file_we);
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic [3:0] op = 4'h0;
    logic       use_lit = 1'b0;
    logic [7:0] lit = 8'h00;
    logic [7:0] file_rdata = 8'h00;
    logic       dest = 1'b0;
    logic [7:0] file_wdata;
    logic       file_we;
    logic [7:0] w_q;
    logic       stat_c, stat_dc, stat_z;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .op(op), .use_lit(use_lit),
        .lit(lit), .file_rdata(file_rdata), .dest(dest),
        .file_wdata(file_wdata), .file_we(file_we), .w_q(w_q),
        .stat_c(stat_c), .stat_dc(stat_dc), .stat_z(stat_z)
    );

    // Fields: w0[8] st0{Z,DC,C}[3] op[4] b[8] use_lit[1] dest[1] res[8] st{Z,DC,C}[3]
    localparam int NV = 19;
    localparam logic [35:0] VEC [0:NV-1] = '{
        {8'h12, 3'b000, 4'h1, 8'h24, 1'b1, 1'b0, 8'h36, 3'b000}, // R3
        {8'hFF, 3'b000, 4'h1, 8'h01, 1'b0, 1'b1, 8'h00, 3'b111}, // R3 R5
        {8'h08, 3'b000, 4'h1, 8'h08, 1'b1, 1'b0, 8'h10, 3'b010}, // R3 DC
        {8'h12, 3'b000, 4'h2, 8'h24, 1'b1, 1'b0, 8'h12, 3'b011}, // R4
        {8'h24, 3'b000, 4'h2, 8'h12, 1'b0, 1'b0, 8'hEE, 3'b000}, // R4 borrow
        {8'h55, 3'b000, 4'h2, 8'h55, 1'b1, 1'b1, 8'h00, 3'b111}, // R4 R5
        {8'hF0, 3'b011, 4'h3, 8'h0F, 1'b1, 1'b0, 8'h00, 3'b111}, // R5 R6
        {8'hF0, 3'b000, 4'h4, 8'h0F, 1'b0, 1'b1, 8'hFF, 3'b000}, // R5
        {8'hAA, 3'b001, 4'h5, 8'hA5, 1'b1, 1'b0, 8'h0F, 3'b001}, // R6
        {8'h00, 3'b010, 4'h6, 8'hFF, 1'b0, 1'b0, 8'h00, 3'b110}, // R6 INC wrap
        {8'h00, 3'b001, 4'h7, 8'h01, 1'b1, 1'b0, 8'h00, 3'b101}, // R6 DEC
        {8'h33, 3'b000, 4'h0, 8'h00, 1'b1, 1'b0, 8'h00, 3'b100}, // R5 MOV
        {8'h00, 3'b100, 4'h8, 8'h5A, 1'b0, 1'b1, 8'hA5, 3'b000}, // R5 COM
        {8'h77, 3'b011, 4'h9, 8'h12, 1'b1, 1'b0, 8'h00, 3'b111}, // R5 CLR
        {8'h00, 3'b000, 4'hA, 8'h81, 1'b0, 1'b0, 8'h02, 3'b001}, // R7
        {8'h00, 3'b101, 4'hA, 8'h40, 1'b1, 1'b1, 8'h81, 3'b100}, // R7
        {8'h00, 3'b000, 4'hB, 8'h01, 1'b0, 1'b0, 8'h00, 3'b001}, // R7 Z kept
        {8'h00, 3'b011, 4'hB, 8'h80, 1'b1, 1'b0, 8'hC0, 3'b010}, // R7
        {8'h3C, 3'b000, 4'hC, 8'h05, 1'b1, 1'b1, 8'h00, 3'b101}  // R8
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [7:0] b, input logic ul,
                         input logic d, input logic en);
        op = o; dest = d; ce = en; use_lit = ul;
        lit        = ul ? b : ~b;
        file_rdata = ul ? ~b : b;
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic preset(input logic [7:0] w0, input logic [2:0] st0);
        drive(4'h0, w0, 1'b1, 1'b0, 1'b1); tick;
        drive(4'hC, {5'b0, st0}, 1'b1, 1'b1, 1'b1); tick;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        // R10: reset state of W, DC, Z
        check(w_q == 8'h00, "R10 W after reset", w_q, 0);
        check({stat_z, stat_dc} == 2'b00, "R10 Z/DC after reset", {stat_z, stat_dc}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [7:0] w0, b, res;
            logic [2:0] st0, st;
            logic [3:0] o;
            logic ul, d, ldst, exp_we;
            {w0, st0, o, b, ul, d, res, st} = VEC[i];
            ldst = (o == 4'hC);
            exp_we = d && !ldst;
            preset(w0, st0);
            drive(o, b, ul, d, 1'b1);
            #3;
            check(file_we == exp_we, "R2 R8 strobe", file_we, exp_we);
            if (exp_we) check(file_wdata == res, "R1 R2 file data", file_wdata, res);
            tick;
            if (exp_we || ldst) check(w_q == w0, "R2 R8 W kept", w_q, w0);
            else check(w_q == res, "R1 R2 W result", w_q, res);
            check({stat_z, stat_dc, stat_c} == st, "R3 R4 R5 R6 R7 R8 flags",
                  {stat_z, stat_dc, stat_c}, st);
        end

        // R9: disabled cycle does nothing
        preset(8'h21, 3'b010);
        drive(4'h1, 8'h7F, 1'b1, 1'b1, 1'b0);
        #3;
        check(file_we == 1'b0, "R9 strobe idle", file_we, 0);
        tick;
        drive(4'h1, 8'h7F, 1'b1, 1'b0, 1'b0); tick;
        check(w_q == 8'h21, "R9 W frozen", w_q, 8'h21);
        check({stat_z, stat_dc, stat_c} == 3'b010, "R9 flags frozen",
              {stat_z, stat_dc, stat_c}, 3'b010);

        // R9: reserved opcodes act as no-ops
        for (int k = 13; k < 16; k++) begin
            drive(4'(k), 8'hFF, 1'b0, 1'b1, 1'b1);
            #3;
            check(file_we == 1'b0, "R9 reserved strobe", file_we, 0);
            tick;
            drive(4'(k), 8'h00, 1'b0, 1'b0, 1'b1); tick;
            check(w_q == 8'h21 && {stat_z, stat_dc, stat_c} == 3'b010,
                  "R9 reserved no change", {w_q, stat_z, stat_dc, stat_c}, {8'h21, 3'b010});
        end

        // R10: reset keeps C=1 even with an update requested
        preset(8'h5A, 3'b111);
        rst_n = 1'b0;
        drive(4'hC, 8'h00, 1'b1, 1'b0, 1'b1); tick;
        rst_n = 1'b1;
        drive(4'h0, 8'h00, 1'b1, 1'b0, 1'b0);
        check(stat_c == 1'b1, "R10 C kept high", stat_c, 1);
        check(w_q == 8'h00, "R10 W cleared", w_q, 0);
        check({stat_z, stat_dc} == 2'b00, "R10 Z/DC cleared", {stat_z, stat_dc}, 0);

        // R10: reset keeps C=0
        preset(8'h11, 3'b000);
        rst_n = 1'b0; tick; rst_n = 1'b1;
        check(stat_c == 1'b0, "R10 C kept low", stat_c, 0);

        // R1 R7: carry chains from one rotate into the next
        preset(8'h00, 3'b000);
        drive(4'hA, 8'h80, 1'b0, 1'b0, 1'b1); tick;
        drive(4'hA, 8'h00, 1'b1, 1'b0, 1'b1); tick;
        check(w_q == 8'h01 && stat_c == 1'b0, "R7 carry chain",
              {w_q, stat_c}, {8'h01, 1'b0});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule